// File: doc/BRIEF.md
# Driver Fault and Standby Supervisor

This block supervises a two-phase motor bridge driver. It watches a low-active standby pin, a motor-supply comparator, a thermal-shutdown flag and an over-current flag, and from them decides whether the chopping oscillator runs and whether the bridge outputs may be driven. While the supply is below its recovery level or standby is held low, nothing runs and every latched fault is wiped.

Both fault inputs pass through a deglitch filter. A fault must be present on a run of consecutive clock samples before it latches. The two faults latch differently. A thermal trip puts the whole driver back into standby, with the oscillator and the bridge both off. An over-current trip only holds the bridge off, and the oscillator keeps running. In both cases the latch holds until standby is asserted or the supply drops out. Each latch is visible on its own status output, so software can see which fault caused the shutdown.

When the driver leaves standby, the oscillator starts at once. The bridge is enabled one chopping period later, after the oscillator has settled.

Top module: `drv_fault_supervisor`

## Requirements
- R1: After asynchronous reset, `bridge_en_o`, `thermal_flag_o` and `overcur_flag_o` are 0.
- R2: `osc_en_o` is 1 exactly when `standby_ni`=1, `supply_ok_i`=1 and no thermal fault is latched, in the same cycle the inputs change; standby low forces both `osc_en_o` and `bridge_en_o` to 0.
- R3: A cycle with `supply_ok_i`=0 turns both enables off and clears both fault flags at that clock edge.
- R4: `bridge_en_o` rises exactly CHOP_CYCLES clock edges after `osc_en_o` rises, provided no over-current fault is latched.
- R5: `thermal_i` high for fewer than DEGLITCH_N consecutive edges leaves `thermal_flag_o` at 0; DEGLITCH_N consecutive edges set it after the last of them.
- R6: A latched thermal fault sets `thermal_flag_o` and forces `osc_en_o` and `bridge_en_o` to 0, and this holds after `thermal_i` falls, until standby or supply loss.
- R7: A latched over-current fault sets `overcur_flag_o` and forces `bridge_en_o` to 0 while `osc_en_o` stays 1, and this holds after `overcur_i` falls, until standby or supply loss.
- R8: `overcur_i` uses the same deglitch rule as R5: fewer than DEGLITCH_N consecutive edges has no effect, and DEGLITCH_N consecutive edges trip the latch.
- R9: A cycle with `standby_ni`=0 clears both flags at that edge. Fault inputs are not counted while the oscillator is off, even if they stay high.
- R10: After a fault is cleared and standby is released, the full CHOP_CYCLES wait of R4 starts again before the bridge is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_ni | input | 1 | Standby request, active low |
| supply_ok_i | input | 1 | Motor supply above recovery level |
| thermal_i | input | 1 | Raw thermal-shutdown flag |
| overcur_i | input | 1 | Raw over-current flag |
| osc_en_o | output | 1 | Chopping oscillator enable |
| bridge_en_o | output | 1 | Bridge output enable |
| thermal_flag_o | output | 1 | Latched thermal fault |
| overcur_flag_o | output | 1 | Latched over-current fault |

## Verification
The hardest case to reach from the ports is a fault input that is still high while the fault is being cleared. Reaching it requires a fault trip, then standby or supply loss, then release, all with the fault input held high. The bench holds `overcur_i` high across a standby pulse and checks three things: the flag stays clear while standby is low, the bridge never turns on after release, and the latch trips again exactly DEGLITCH_N edges after release, during the start-up wait. Pulses one sample shorter than the deglitch length on each fault input show that the filter counts exactly.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  localparam int unsigned NUM_FAULTS = 2;
  localparam int unsigned FLT_THERM  = 0;
  localparam int unsigned FLT_OVCUR  = 1;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WARM = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fault_deglitch.sv
module fault_deglitch #(
  parameter int unsigned DEGLITCH_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic sample_i,
  output logic latch_o
);
  localparam int unsigned CW = (DEGLITCH_N > 1) ? $clog2(DEGLITCH_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH_N - 1);

  logic [CW-1:0] cnt_q;
  logic          latch_q;
  logic          hit;

  assign hit = en_i & sample_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || !sample_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
    end else if (clr_i) begin
      latch_q <= 1'b0;
    end else if (hit) begin
      latch_q <= 1'b1;
    end
  end

  assign latch_o = latch_q;

  // trip only follows a sample taken while running
  assert_trip_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(sample_i) && $past(en_i));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q);
endmodule

// File: rtl/start_sequencer.sv
module start_sequencer
  import drv_sup_pkg::*;
#(
  parameter int unsigned CHOP_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  output logic ready_o
);
  localparam int unsigned CW = (CHOP_CYCLES > 1) ? $clog2(CHOP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHOP_CYCLES - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else if (!osc_en_i) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_OFF: begin
          cnt_q   <= CW'(1);
          state_q <= (CHOP_CYCLES <= 1) ? SEQ_RUN : SEQ_WARM;
        end
        SEQ_WARM: begin
          if (cnt_q == LAST) state_q <= SEQ_RUN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign ready_o = (state_q == SEQ_RUN);

  assert_ready_after_warm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(osc_en_i));

  assert_ready_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> !ready_o);
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import drv_sup_pkg::*;
#(
  parameter int unsigned DEGLITCH_N  = 4,
  parameter int unsigned CHOP_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_ni,
  input  logic supply_ok_i,
  input  logic thermal_i,
  input  logic overcur_i,
  output logic osc_en_o,
  output logic bridge_en_o,
  output logic thermal_flag_o,
  output logic overcur_flag_o
);
  logic [NUM_FAULTS-1:0] flt_raw;
  logic [NUM_FAULTS-1:0] flt_q;
  logic                  clr;
  logic                  run;
  logic                  ready;

  assign flt_raw[FLT_THERM] = thermal_i;
  assign flt_raw[FLT_OVCUR] = overcur_i;

  // standby or supply loss is the only recovery path
  assign clr = ~supply_ok_i | ~standby_ni;
  assign run = supply_ok_i & standby_ni & ~flt_q[FLT_THERM];

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_flt
    fault_deglitch #(.DEGLITCH_N(DEGLITCH_N)) u_dg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (run),
      .clr_i    (clr),
      .sample_i (flt_raw[g]),
      .latch_o  (flt_q[g])
    );
  end

  start_sequencer #(.CHOP_CYCLES(CHOP_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (run),
    .ready_o  (ready)
  );

  assign osc_en_o       = run;
  assign bridge_en_o    = run & ready & ~flt_q[FLT_OVCUR];
  assign thermal_flag_o = flt_q[FLT_THERM];
  assign overcur_flag_o = flt_q[FLT_OVCUR];

  assert_therm_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_flag_o && standby_ni && supply_ok_i |=> thermal_flag_o);

  assert_therm_stops_osc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thermal_flag_o) |-> !osc_en_o);

  assert_ovcur_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overcur_flag_o && standby_ni && supply_ok_i |=> overcur_flag_o);

  assert_supply_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !thermal_flag_o && !overcur_flag_o);

  assert_bridge_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !bridge_en_o);
endmodule

// File: tb/drv_fault_supervisor_tb_top.sv
module drv_fault_supervisor_tb_top;
  localparam int N = 4;
  localparam int C = 16;

  logic clk = 0, rst_n = 0;
  logic sb_n = 0, sup = 0, th = 0, oc = 0;
  logic osc_en, br_en, th_flag, oc_flag;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  drv_fault_supervisor #(.DEGLITCH_N(N), .CHOP_CYCLES(C)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_ni(sb_n), .supply_ok_i(sup),
    .thermal_i(th), .overcur_i(oc), .osc_en_o(osc_en), .bridge_en_o(br_en),
    .thermal_flag_o(th_flag), .overcur_flag_o(oc_flag));

  // behavioural reference
  bit m_th, m_oc, m_rdy;
  int c_th, c_oc, c_warm;

  function automatic bit m_active();
    return sup && sb_n && !m_th;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_th = 0; m_oc = 0; m_rdy = 0; c_th = 0; c_oc = 0; c_warm = 0;
    end else begin
      bit run, clr;
      run = m_active();
      clr = !sup || !sb_n;
      c_th = (run && th) ? c_th + 1 : 0;
      c_oc = (run && oc) ? c_oc + 1 : 0;
      if (run) begin c_warm++; m_rdy = (c_warm >= C); end
      else begin c_warm = 0; m_rdy = 0; end
      if (clr) begin m_th = 0; m_oc = 0; end
      else begin
        if (c_th >= N) m_th = 1;
        if (c_oc >= N) m_oc = 1;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(osc_en,  m_active(), "R2 osc_en");
      chk(br_en,   m_active() && m_rdy && !m_oc, "R4 bridge_en");
      chk(th_flag, m_th, "R6 thermal_flag");
      chk(oc_flag, m_oc, "R7 overcur_flag");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look();
    #2;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    look();
    chk(br_en, 0, "R1 bridge after reset");
    chk(th_flag, 0, "R1 thermal flag after reset");
    chk(oc_flag, 0, "R1 overcur flag after reset");

    // start-up wait
    cyc(1); sup = 1; sb_n = 1;
    look(); chk(osc_en, 1, "R2 osc starts at release");
    cyc(C - 1); look(); chk(br_en, 0, "R4 bridge one cycle early");
    cyc(1); look(); chk(br_en, 1, "R4 bridge on after chop period");

    // thermal glitch then real trip
    cyc(1); th = 1; cyc(N - 1); th = 0;
    look(); chk(th_flag, 0, "R5 short thermal pulse ignored");
    chk(br_en, 1, "R5 bridge kept on");
    cyc(1); th = 1; cyc(N);
    look(); chk(th_flag, 1, "R5 thermal trips after N samples");
    chk(osc_en, 0, "R6 osc off on thermal");
    th = 0; cyc(6); look();
    chk(th_flag, 1, "R6 thermal latch holds");
    chk(br_en, 0, "R6 bridge stays off");
    sb_n = 0; cyc(1); look();
    chk(th_flag, 0, "R9 standby clears thermal");
    sb_n = 1; look(); chk(osc_en, 1, "R10 osc restarts");
    cyc(C - 1); look(); chk(br_en, 0, "R10 wait repeated");
    cyc(1); look(); chk(br_en, 1, "R10 bridge back on");

    // over-current glitch then trip
    cyc(1); oc = 1; cyc(N - 1); oc = 0;
    look(); chk(oc_flag, 0, "R8 short overcur pulse ignored");
    cyc(1); oc = 1; cyc(N);
    look(); chk(oc_flag, 1, "R8 overcur trips after N samples");
    chk(br_en, 0, "R7 bridge off on overcur");
    chk(osc_en, 1, "R7 osc keeps running");
    oc = 0; cyc(8); look(); chk(oc_flag, 1, "R7 overcur latch holds");
    sup = 0; cyc(1); look();
    chk(oc_flag, 0, "R3 supply loss clears overcur");
    chk(osc_en, 0, "R3 osc off without supply");
    sup = 1; cyc(C); look(); chk(br_en, 1, "R3 recovery after supply");

    // fault held high across a standby pulse
    oc = 1; cyc(N); look(); chk(oc_flag, 1, "R7 trip again");
    sb_n = 0; cyc(5); look();
    chk(oc_flag, 0, "R9 no counting in standby");
    sb_n = 1; cyc(N - 1); look(); chk(oc_flag, 0, "R9 recount from zero");
    cyc(1); look(); chk(oc_flag, 1, "R9 retrip N edges after release");
    cyc(C); look(); chk(br_en, 0, "R7 bridge never enabled");
    oc = 0; sb_n = 0; cyc(2); look();
    chk(br_en, 0, "R2 standby forces bridge off");
    chk(osc_en, 0, "R2 standby forces osc off");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule